// File: doc/BRIEF.md
# Bank Group Column Spacing Checker

This block sits inside a memory channel scheduler and answers one question every cycle: may the candidate column command (a read or a write, aimed at a bank group and a bank) issue now? Banks of one group share an internal data bus, so two column commands of the same direction to the same group must be kept apart by a long gap. Separate groups own separate buses, so commands to different groups need only a short gap. The scheduler presents its candidate, reads `legal_o` in the same cycle, and raises `issue_i` when it sends the command. The block then records that issue.

Reads and writes are tracked by two independent trackers. Each tracker holds one cycle counter per bank group, restarted by an issue to that group. It also holds one counter for the direction as a whole, restarted by any issue of that direction. Every counter stops at its maximum value, and reset loads that maximum, so nothing is blocked after reset. Each tracker has a small state machine, computed from the next counter values:

- `SP_OPEN`: every counter is past its gap.
- `SP_ALL_HOLD`: the direction counter is still below the short gap.
- `SP_GROUP_HOLD`: the short gap has elapsed but at least one group counter is below the long gap.

The transitions are as follows. Any issue moves the tracker to `SP_ALL_HOLD`, unless the short gap is one cycle; in that case it moves to `SP_GROUP_HOLD`, or to `SP_OPEN` when the long gap is also one cycle. `SP_ALL_HOLD` moves to `SP_GROUP_HOLD` once the short gap elapses. `SP_GROUP_HOLD` moves to `SP_OPEN` once the last group reaches the long gap. Reset enters `SP_OPEN`.

The two gap values are programmable. Before use they are made consistent: the short gap is at least one cycle, and the long gap is at least the short gap.

Top module: `bank_group_spacing`

## Requirements
- R1: After reset is released, a candidate of either direction (`cand_kind_i` 0 = read, 1 = write) and any group is legal until an issue of that direction occurs.
- R2: After an issue of one direction in cycle t, no candidate of that direction is legal in cycles t+1 up to t+S-1, where S is the effective short gap.
- R3: After an issue of one direction to group g in cycle t, a candidate of that direction to group g is not legal in cycles t+1 up to t+L-1, where L is the effective long gap.
- R4: A candidate becomes legal in the exact cycle in which both conditions hold: S cycles have passed since the last issue of its direction, and L cycles have passed since the last issue of its direction to its group.
- R5: Issues of one direction never affect the legality of the other direction.
- R6: The bank index (`cand_bank_i`) has no effect on legality; only the group and direction count.
- R7: A short-gap setting of 0 is treated as 1, so with both settings 0 a command may issue every cycle.
- R8: A long-gap setting below the effective short gap is raised to the effective short gap.
- R9: Once a candidate is legal, it stays legal in later cycles with the same direction and group until the next issue of that direction.
- R10: Counters stop at their maximum and never wrap, so an arbitrarily long idle gap leaves a command legal.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_same_gap_i | input | TW | Long gap in cycles, same bank group |
| cfg_cross_gap_i | input | TW | Short gap in cycles, any group of the same direction |
| cand_kind_i | input | 1 | Candidate direction: 0 read, 1 write |
| cand_group_i | input | GW | Candidate bank group |
| cand_bank_i | input | BW | Candidate bank within its group |
| issue_i | input | 1 | Candidate is issued this cycle |
| legal_o | output | 1 | Candidate may issue this cycle |

## Verification
The block is tried with four kinds of input.

- **Directed probes.** A probe repeats one group after an issue, so its answer changes first at the short gap and then at the long gap. This separates the direction-wide limit from the per-group limit.
- **Other-group and other-direction probes.** These show that a hold does not spread to other groups or to the opposite direction. Changing only the bank shows that the bank plays no part.
- **Pseudo-random streams.** Under several gap settings, random candidates that issue whenever they are allowed create overlapping holds across groups.
- **Degenerate and extreme settings.** Gap settings of zero, a long gap below the short gap, and an idle stretch longer than the counter range check the clamping and the saturation.

// File: rtl/bgcs_pkg.sv
package bgcs_pkg;

    typedef enum logic {
        KIND_RD = 1'b0,
        KIND_WR = 1'b1
    } col_kind_e;

    typedef enum logic [1:0] {
        SP_OPEN       = 2'd0,
        SP_GROUP_HOLD = 2'd1,
        SP_ALL_HOLD   = 2'd2
    } spc_state_e;

    localparam int unsigned NUM_KINDS = 2;

endpackage

// File: rtl/bgcs_cfg_clamp.sv
// Turns raw gap settings into a consistent pair: short >= 1, long >= short.
module bgcs_cfg_clamp #(
    parameter int unsigned TW = 6
) (
    input  logic [TW-1:0] raw_long_i,
    input  logic [TW-1:0] raw_short_i,
    output logic [TW-1:0] eff_long_o,
    output logic [TW-1:0] eff_short_o
);

    localparam logic [TW-1:0] MIN_GAP = TW'(1);

    always_comb begin
        eff_short_o = (raw_short_i < MIN_GAP) ? MIN_GAP : raw_short_i;
        eff_long_o  = (raw_long_i < eff_short_o) ? eff_short_o : raw_long_i;
    end

endmodule

// File: rtl/bgcs_gap_timer.sv
// Cycles since the last restart, held at the maximum; reset loads the maximum.
module bgcs_gap_timer #(
    parameter int unsigned TW = 6
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          restart_i,
    output logic [TW-1:0] cnt_q_o,
    output logic [TW-1:0] cnt_d_o
);

    localparam logic [TW-1:0] SAT_VAL = {TW{1'b1}};
    localparam logic [TW-1:0] ONE_VAL = TW'(1);

    always_comb begin
        if (restart_i) begin
            cnt_d_o = ONE_VAL;
        end else if (cnt_q_o == SAT_VAL) begin
            cnt_d_o = SAT_VAL;
        end else begin
            cnt_d_o = cnt_q_o + ONE_VAL;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q_o <= SAT_VAL;
        end else begin
            cnt_q_o <= cnt_d_o;
        end
    end

endmodule

// File: rtl/bgcs_dir_tracker.sv
// Spacing state for one command direction: a counter per bank group,
// a direction-wide counter, and a three-state hold machine.
module bgcs_dir_tracker
    import bgcs_pkg::*;
#(
    parameter int unsigned NUM_GROUPS = 4,
    parameter int unsigned TW         = 6,
    parameter int unsigned GW         = 2
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [TW-1:0] eff_long_i,
    input  logic [TW-1:0] eff_short_i,
    input  logic [GW-1:0] cand_group_i,
    input  logic          issue_i,
    output logic          legal_o
);

    logic [TW-1:0] grp_q [NUM_GROUPS];
    logic [TW-1:0] grp_d [NUM_GROUPS];
    logic [TW-1:0] dir_q;
    logic [TW-1:0] dir_d;

    spc_state_e state_q;
    spc_state_e state_d;

    logic          any_group_short;
    logic [TW-1:0] sel_grp_cnt;

    // one timer per bank group
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp_timer
        logic restart_g;
        assign restart_g = issue_i && (cand_group_i == GW'(g));

        bgcs_gap_timer #(
            .TW (TW)
        ) u_timer (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .restart_i (restart_g),
            .cnt_q_o   (grp_q[g]),
            .cnt_d_o   (grp_d[g])
        );
    end

    // direction-wide timer
    bgcs_gap_timer #(
        .TW (TW)
    ) u_dir_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (issue_i),
        .cnt_q_o   (dir_q),
        .cnt_d_o   (dir_d)
    );

    // next state from the counter values that will be loaded at this edge
    always_comb begin
        any_group_short = 1'b0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (grp_d[g] < eff_long_i) begin
                any_group_short = 1'b1;
            end
        end
        if (dir_d < eff_short_i) begin
            state_d = SP_ALL_HOLD;
        end else if (any_group_short) begin
            state_d = SP_GROUP_HOLD;
        end else begin
            state_d = SP_OPEN;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= SP_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    // counter of the candidate's group
    always_comb begin
        sel_grp_cnt = '0;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (cand_group_i == GW'(g)) begin
                sel_grp_cnt = grp_q[g];
            end
        end
    end

    always_comb begin
        unique case (state_q)
            SP_OPEN:       legal_o = 1'b1;
            SP_GROUP_HOLD: legal_o = (sel_grp_cnt >= eff_long_i);
            SP_ALL_HOLD:   legal_o = 1'b0;
            default:       legal_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/bank_group_spacing.sv
module bank_group_spacing
    import bgcs_pkg::*;
#(
    parameter int unsigned NUM_GROUPS      = 4,
    parameter int unsigned BANKS_PER_GROUP = 4,
    parameter int unsigned TW              = 6,
    localparam int unsigned GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
    localparam int unsigned BW = (BANKS_PER_GROUP > 1) ? $clog2(BANKS_PER_GROUP) : 1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [TW-1:0] cfg_same_gap_i,
    input  logic [TW-1:0] cfg_cross_gap_i,
    input  logic          cand_kind_i,
    input  logic [GW-1:0] cand_group_i,
    input  logic [BW-1:0] cand_bank_i,
    input  logic          issue_i,
    output logic          legal_o
);

    logic [TW-1:0]        eff_long;
    logic [TW-1:0]        eff_short;
    logic [NUM_KINDS-1:0] kind_legal;

    // banks share their group's bus, so the bank index takes no part
    logic unused_bank;
    assign unused_bank = ^cand_bank_i;

    bgcs_cfg_clamp #(
        .TW (TW)
    ) u_clamp (
        .raw_long_i  (cfg_same_gap_i),
        .raw_short_i (cfg_cross_gap_i),
        .eff_long_o  (eff_long),
        .eff_short_o (eff_short)
    );

    for (genvar k = 0; k < NUM_KINDS; k++) begin : g_kind
        logic issue_k;
        assign issue_k = issue_i && (cand_kind_i == 1'(k));

        bgcs_dir_tracker #(
            .NUM_GROUPS (NUM_GROUPS),
            .TW         (TW),
            .GW         (GW)
        ) u_track (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .eff_long_i   (eff_long),
            .eff_short_i  (eff_short),
            .cand_group_i (cand_group_i),
            .issue_i      (issue_k),
            .legal_o      (kind_legal[k])
        );
    end

    assign legal_o = kind_legal[cand_kind_i];

endmodule

// File: rtl/bgcs_checker.sv
module bgcs_checker #(
    parameter int unsigned TW = 6,
    parameter int unsigned GW = 2
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic [TW-1:0] cfg_same_gap_i,
    input logic [TW-1:0] cfg_cross_gap_i,
    input logic          cand_kind_i,
    input logic [GW-1:0] cand_group_i,
    input logic          issue_i,
    input logic          legal_o
);

    // first cycle after reset release: nothing is held
    assert_open_after_reset_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rst_ni) |-> legal_o);

    // same direction right after an issue is held when the short gap exceeds one
    assert_short_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(issue_i) && (cand_kind_i == $past(cand_kind_i)) && (cfg_cross_gap_i > TW'(1)))
        |-> !legal_o);

    // same direction and group right after an issue is held when the long gap exceeds one
    assert_long_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(issue_i) && (cand_kind_i == $past(cand_kind_i))
         && (cand_group_i == $past(cand_group_i)) && (cfg_same_gap_i > TW'(1)))
        |-> !legal_o);

    // legality does not fall back without an issue
    assert_stays_legal_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(issue_i) && $past(legal_o) && $stable(cand_kind_i) && $stable(cand_group_i))
        |-> legal_o);

endmodule

bind bank_group_spacing bgcs_checker #(.TW(TW), .GW(GW)) u_bgcs_checker (.*);

// File: tb/bank_group_spacing_bench.sv
module bank_group_spacing_bench;

    localparam int PERIOD = 10;
    localparam int TW     = 6;
    localparam int NG     = 4;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [TW-1:0] cfg_same_gap_i = '0;
    logic [TW-1:0] cfg_cross_gap_i = '0;
    logic          cand_kind_i = 1'b0;
    logic [1:0]    cand_group_i = '0;
    logic [1:0]    cand_bank_i = '0;
    logic          issue_i = 1'b0;
    logic          legal_o;

    always #(PERIOD/2) clk_i = ~clk_i;

    bank_group_spacing u_bank_group_spacing (
        .clk_i           (clk_i),
        .rst_ni          (rst_ni),
        .cfg_same_gap_i  (cfg_same_gap_i),
        .cfg_cross_gap_i (cfg_cross_gap_i),
        .cand_kind_i     (cand_kind_i),
        .cand_group_i    (cand_group_i),
        .cand_bank_i     (cand_bank_i),
        .issue_i         (issue_i),
        .legal_o         (legal_o)
    );

    int vectors = 0;
    int miscompares = 0;
    int cyc = 0;
    int effl = 1;
    int effs = 1;
    int last_grp [2][NG];
    int last_dir [2];
    int unsigned seed = 32'h1234_5678;

    function automatic bit model_legal(input int k, input int g);
        bit dir_ok;
        bit grp_ok;
        dir_ok = (last_dir[k] < 0) || (cyc - last_dir[k] >= effs);
        grp_ok = (last_grp[k][g] < 0) || (cyc - last_grp[k][g] >= effl);
        return dir_ok && grp_ok;
    endfunction

    function automatic string auto_tag(input int k, input int g);
        if (last_dir[k] < 0) return "R1";
        if (cyc - last_dir[k] < effs) return "R2";
        if (last_grp[k][g] >= 0 && cyc - last_grp[k][g] < effl) return "R3";
        return "R4";
    endfunction

    function automatic int unsigned next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic do_reset(input int same_gap, input int cross_gap);
        @(negedge clk_i);
        rst_ni = 1'b0;
        issue_i = 1'b0;
        cfg_same_gap_i = TW'(same_gap);
        cfg_cross_gap_i = TW'(cross_gap);
        effs = (cross_gap < 1) ? 1 : cross_gap;
        effl = (same_gap < effs) ? effs : same_gap;
        for (int k = 0; k < 2; k++) begin
            last_dir[k] = -1;
            for (int g = 0; g < NG; g++) last_grp[k][g] = -1;
        end
        @(negedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
    endtask

    // one cycle: drive candidate, compare, optionally issue when allowed
    task automatic step(input int k, input int g, input int b, input bit want, input string tag);
        bit    expv;
        string t;
        @(negedge clk_i);
        issue_i = 1'b0;
        cand_kind_i = 1'(k);
        cand_group_i = 2'(g);
        cand_bank_i = 2'(b);
        #1;
        expv = model_legal(k, g);
        t = (tag == "") ? auto_tag(k, g) : tag;
        vectors++;
        if (legal_o !== expv) begin
            miscompares++;
            $display("FAIL %s: cycle %0d kind %0d group %0d bank %0d legal_o=%0b expected %0b",
                     t, cyc, k, g, b, legal_o, expv);
        end
        if (want && expv) begin
            issue_i = 1'b1;
            last_dir[k] = cyc;
            last_grp[k][g] = cyc;
        end
        cyc++;
    endtask

    task automatic random_run(input int n);
        for (int i = 0; i < n; i++) begin
            int unsigned r;
            r = next_rand();
            step(int'(r[0]), int'(r[2:1]), int'(r[4:3]), r[5] | r[6], "");
        end
    endtask

    initial begin
        #(PERIOD * 100000);
        miscompares++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R1: reset state, long 4 / short 2
        do_reset(4, 2);
        step(0, 0, 0, 0, "R1");
        step(1, 3, 2, 0, "R1");
        // R2 then R3 then R4 on one group
        step(0, 0, 0, 1, "");
        for (int i = 0; i < 6; i++) step(0, 0, i % 4, 0, "");
        // other group: only the short gap applies
        step(0, 1, 0, 1, "");
        for (int i = 0; i < 4; i++) step(0, 2, 0, 0, "");
        // R5: write right after a read to the same group
        step(0, 2, 1, 1, "");
        step(1, 2, 1, 1, "R5");
        step(0, 3, 0, 0, "R5");
        // R6: bank changes only
        step(0, 1, 0, 1, "");
        for (int i = 0; i < 6; i++) step(0, 1, (i * 3) % 4, 0, "R6");
        random_run(400);

        do_reset(6, 3);
        random_run(300);

        do_reset(3, 1);
        random_run(300);

        // R7: zero settings -> one command every cycle
        do_reset(0, 0);
        for (int i = 0; i < 20; i++) step(i % 2, 0, i % 4, 1, "R7");

        // R8: long below short
        do_reset(2, 5);
        step(0, 0, 0, 1, "");
        for (int i = 0; i < 7; i++) step(0, 0, 0, 0, "R8");
        step(1, 3, 0, 1, "");
        for (int i = 0; i < 7; i++) step(1, 2, 0, 0, "R8");
        random_run(200);

        // R9 and R10: long hold, then an idle stretch past the counter range
        do_reset(50, 3);
        step(1, 2, 0, 1, "");
        for (int i = 0; i < 10; i++) step(1, 1, 0, 0, "R9");
        for (int i = 0; i < 80; i++) step(1, 2, i % 4, 0, "R10");
        step(1, 2, 0, 1, "");
        for (int i = 0; i < 70; i++) step(1, 2, 0, 0, "R10");

        @(negedge clk_i);
        issue_i = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule